// File: doc/BRIEF.md
# Low-Power Timer Event Flag Unit

This block is a small up-counting timer with the status logic built around it. The timer sits idle until a rising edge on the trigger input starts it. It then counts up once per clock from zero to a programmable reload value and wraps back to zero. A programmable compare value marks a point inside each period. A repetition down-counter groups overflows, so that an update event occurs only once every N+1 periods.

Four sticky status flags record the events: trigger, compare match, overflow and update. Three wakeup flags record compare, overflow and update a second time, and they follow a stricter clearing rule. A simple synchronous write port and a combinational read port give access to the configuration registers, the enables, the clear register and the status word. One interrupt line and one wakeup line summarise the enabled flags. A stop input halts the timer and returns it to idle, so that the next trigger edge can start it again.

Top module: `lptim_evt_unit`

## Requirements
- R1: After synchronous reset, every register reads zero, all flags are clear, and `irq` and `wake` are low. The register addresses are: 0 reload, 1 compare, 2 repetition, 3 interrupt enable, 4 wakeup enable, 5 clear, 6 status.
- R2: A rising edge on `trig_in` while the timer is idle starts the timer with the counter at zero, and sets status bit 0 at that clock edge. While `tmr_stop` is high the timer is forced idle, the counter returns to zero and no event is produced.
- R3: A rising edge on `trig_in` while the timer is running is ignored and leaves status bit 0 unchanged.
- R4: While the timer is running, the counter advances by one on each clock. Status bit 1 sets on the clock edge that ends a cycle in which the counter equals the compare value.
- R5: When the running counter equals the reload value, it wraps to zero on the next edge, and status bit 2 (overflow) sets.
- R6: The repetition counter loads from the repetition register when the timer starts. At each overflow it reloads if it is zero and decrements otherwise. Status bit 3 (update) sets only on an overflow that finds it at zero.
- R7: The wakeup flags, in status bits 4 (compare), 5 (overflow) and 6 (update), set on the same events as their status counterparts, whatever the enable settings.
- R8: Writing 1 to clear-register bits 0 to 3 clears the matching status flag. Writing 0 changes nothing. The clear register reads zero.
- R9: Writing 1 to clear-register bit 4 clears only those wakeup flags whose wakeup-enable bit is 0. Wakeup-enable bit 0 is compare, bit 1 is overflow and bit 2 is update. Wakeup flags that are still enabled are kept.
- R10: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R11: `irq` is the OR of status bits 0 to 3, each ANDed with the matching interrupt-enable bit. `wake` is the OR of the three wakeup flags, each ANDed with the matching wakeup-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | External trigger; a rising edge starts an idle timer |
| tmr_stop | input | 1 | Forces the timer idle and the counter to zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CW | Read data (combinational) |
| irq | output | 1 | Combined enabled-interrupt output |
| wake | output | 1 | Combined enabled-wakeup output |

## Verification
The main counting function is driven through a table of reload, compare and repetition settings, each sampled a chosen number of cycles after the start. This separates the cases before compare, at compare, at the first overflow with and without a pending repetition, at the second overflow, and with a compare value that is never reached. Directed tests then place a trigger edge while the timer runs, a clear in the very cycle of an overflow, a clear write of zeros, and wakeup clears with the enable still set and then cleared. Each of these is checked against the status word and the two summary outputs.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int ADDR_W    = 3;
    localparam int N_EVT     = 4;
    localparam int N_WK      = 3;
    localparam int WK_CLR_B  = 4;
    localparam int STAT_W    = N_EVT + N_WK;

    typedef enum logic [ADDR_W-1:0] {
        RA_RELOAD = 3'd0,
        RA_CMP    = 3'd1,
        RA_REP    = 3'd2,
        RA_IEN    = 3'd3,
        RA_WEN    = 3'd4,
        RA_CLR    = 3'd5,
        RA_STAT   = 3'd6
    } reg_addr_e;

    // bit 0 trigger, 1 compare, 2 overflow, 3 update
    typedef struct packed {
        logic upd;
        logic ovf;
        logic cmp;
        logic trg;
    } evt_t;

    // bit 0 compare, 1 overflow, 2 update
    typedef struct packed {
        logic upd;
        logic ovf;
        logic cmp;
    } wk_t;

    function automatic logic [STAT_W-1:0] pack_status(evt_t s, wk_t w);
        return {w, s};
    endfunction

    function automatic wk_t wake_events(evt_t e);
        wk_t w;
        w.cmp = e.cmp;
        w.ovf = e.ovf;
        w.upd = e.upd;
        return w;
    endfunction
endpackage

// File: rtl/lpt_counter.sv
module lpt_counter
    import lpt_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig_in,
    input  logic          tmr_stop,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] cmp_val,
    input  logic [RW-1:0] rep_val,
    output evt_t          ev,
    output logic          running
);
    logic          trig_q;
    logic [CW-1:0] cnt;
    logic [RW-1:0] rep_cnt;
    logic          rise, wrap;

    assign rise   = trig_in & ~trig_q;
    assign wrap   = running & ~tmr_stop & (cnt == reload);
    assign ev.trg = rise & ~running & ~tmr_stop;
    assign ev.cmp = running & ~tmr_stop & (cnt == cmp_val);
    assign ev.ovf = wrap;
    assign ev.upd = wrap & (rep_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
            rep_cnt <= '0;
        end else begin
            trig_q <= trig_in;
            if (tmr_stop) begin
                running <= 1'b0;
                cnt     <= '0;
            end else if (ev.trg) begin
                running <= 1'b1;
                cnt     <= '0;
                rep_cnt <= rep_val;
            end else if (running) begin
                cnt <= wrap ? '0 : cnt + 1'b1;
                if (wrap)
                    rep_cnt <= (rep_cnt == '0) ? rep_val : rep_cnt - 1'b1;
            end
        end
    end

    // R5
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ev.ovf |=> (cnt == '0));

    // R6
    rep_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.upd && !ev.trg) |=> (rep_cnt == $past(rep_val)));
endmodule

// File: rtl/lpt_flags.sv
module lpt_flags
    import lpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  evt_t            ev,
    input  logic [N_EVT-1:0] clr_evt,
    input  logic            clr_wake,
    input  logic [N_WK-1:0] wen,
    output evt_t            sts,
    output wk_t             wk
);
    logic [N_EVT-1:0] ev_v, sts_v;
    logic [N_WK-1:0]  wev_v, wk_v;

    assign ev_v  = ev;
    assign wev_v = wake_events(ev);
    assign sts   = sts_v;
    assign wk    = wk_v;

    for (genvar i = 0; i < N_EVT; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (rst) sts_v[i] <= 1'b0;
            else     sts_v[i] <= (sts_v[i] & ~clr_evt[i]) | ev_v[i];
        end
    end

    for (genvar j = 0; j < N_WK; j++) begin : g_wk
        always_ff @(posedge clk) begin
            if (rst) wk_v[j] <= 1'b0;
            else     wk_v[j] <= (wk_v[j] & ~(clr_wake & ~wen[j])) | wev_v[j];
        end
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.ovf && clr_evt[2]) |=> sts.ovf);

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wake && wen[2] && wk.upd) |=> wk.upd);

    // R7
    wk_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wk.cmp) |-> $past(ev.cmp));
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [STAT_W-1:0] status,
    output logic [CW-1:0]     rd_data,
    output logic [CW-1:0]     reload,
    output logic [CW-1:0]     cmp_val,
    output logic [RW-1:0]     rep_val,
    output logic [N_EVT-1:0]  ien,
    output logic [N_WK-1:0]   wen,
    output logic [N_EVT-1:0]  clr_evt,
    output logic              clr_wake
);
    logic clr_hit;

    assign clr_hit  = wr_en && (wr_addr == RA_CLR);
    assign clr_evt  = clr_hit ? wr_data[N_EVT-1:0] : '0;
    assign clr_wake = clr_hit & wr_data[WK_CLR_B];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload  <= '0;
            cmp_val <= '0;
            rep_val <= '0;
            ien     <= '0;
            wen     <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_RELOAD: reload  <= wr_data;
                RA_CMP:    cmp_val <= wr_data;
                RA_REP:    rep_val <= wr_data[RW-1:0];
                RA_IEN:    ien     <= wr_data[N_EVT-1:0];
                RA_WEN:    wen     <= wr_data[N_WK-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_RELOAD: rd_data = reload;
            RA_CMP:    rd_data = cmp_val;
            RA_REP:    rd_data[RW-1:0]     = rep_val;
            RA_IEN:    rd_data[N_EVT-1:0]  = ien;
            RA_WEN:    rd_data[N_WK-1:0]   = wen;
            RA_STAT:   rd_data[STAT_W-1:0] = status;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lptim_evt_unit.sv
module lptim_evt_unit
    import lpt_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              tmr_stop,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    output logic              irq,
    output logic              wake
);
    evt_t             ev, sts;
    wk_t              wk;
    logic             running;
    logic [CW-1:0]    reload, cmp_val;
    logic [RW-1:0]    rep_val;
    logic [N_EVT-1:0] ien, clr_evt;
    logic [N_WK-1:0]  wen;
    logic             clr_wake;

    lpt_regs #(.CW(CW), .RW(RW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status(pack_status(sts, wk)),
        .rd_data(rd_data), .reload(reload), .cmp_val(cmp_val),
        .rep_val(rep_val), .ien(ien), .wen(wen), .clr_evt(clr_evt),
        .clr_wake(clr_wake)
    );

    lpt_counter #(.CW(CW), .RW(RW)) u_cnt (
        .clk(clk), .rst(rst), .trig_in(trig_in), .tmr_stop(tmr_stop),
        .reload(reload), .cmp_val(cmp_val), .rep_val(rep_val),
        .ev(ev), .running(running)
    );

    lpt_flags u_flags (
        .clk(clk), .rst(rst), .ev(ev), .clr_evt(clr_evt),
        .clr_wake(clr_wake), .wen(wen), .sts(sts), .wk(wk)
    );

    assign irq  = |(N_EVT'(sts) & ien);
    assign wake = |(N_WK'(wk) & wen);

    // R4
    cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ev.cmp |=> sts.cmp);

    // R3
    trig_run_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !sts.trg && !ev.trg) |=> !sts.trg);
endmodule

// File: tb/lptim_evt_unit_test.sv
module lptim_evt_unit_test;
    localparam int CLK_P = 10;
    localparam int CW = 16;

    logic clk = 0, rst = 1, trig_in = 0, tmr_stop = 0, wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [CW-1:0] wr_data = 0;
    logic [CW-1:0] rd_data;
    logic irq, wake;
    int total = 0, bad = 0;
    bit done = 0;

    lptim_evt_unit #(.CW(CW), .RW(8)) uut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .tmr_stop(tmr_stop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    always #(CLK_P/2) clk = ~clk;

    // reload, compare, repetition, cycles after start, expected status
    localparam logic [55:0] VEC [0:5] = '{
        {16'd5, 16'd3, 8'd0, 8'd2,  8'h01},
        {16'd5, 16'd3, 8'd0, 8'd4,  8'h13},
        {16'd5, 16'd3, 8'd0, 8'd6,  8'h7F},
        {16'd5, 16'd3, 8'd1, 8'd6,  8'h37},
        {16'd5, 16'd3, 8'd1, 8'd12, 8'h7F},
        {16'd5, 16'd9, 8'd0, 8'd6,  8'h6D}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [CW-1:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic prep(input logic [CW-1:0] ar, input logic [CW-1:0] cp, input logic [7:0] rp);
        trig_in = 0; tmr_stop = 1;
        tick();
        tmr_stop = 0;
        wr(3'd4, 0);
        wr(3'd5, 16'h1F);
        wr(3'd0, ar);
        wr(3'd1, cp);
        wr(3'd2, 16'(rp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R1 reset state
        for (int a = 0; a < 7; a++) rd_chk("R1", 3'(a), '0);
        chk("R1 irq", 16'(irq), 0);
        chk("R1 wake", 16'(wake), 0);

        // table walk: R2 R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            prep(VEC[i][55:40], VEC[i][39:24], VEC[i][23:16]);
            trig_in = 1;
            tick();
            repeat (int'(VEC[i][15:8])) tick();
            rd_chk("R2/R4/R5/R6/R7 table", 3'd6, 16'(VEC[i][7:0]));
        end

        // R3: edge while running ignored
        prep(20, 15, 0);
        trig_in = 1; tick();
        rd_chk("R2 start", 3'd6, 16'h01);
        trig_in = 0; tick();
        wr(3'd5, 16'h01);
        rd_chk("R8 clear trg", 3'd6, 16'h00);
        trig_in = 1; tick(); tick();
        rd_chk("R3 ignored", 3'd6, 16'h00);

        // R10: clear coincides with overflow
        prep(3, 9, 0);
        trig_in = 1; tick();
        repeat (3) tick();
        wr(3'd5, 16'h04);
        rd_chk("R10 set wins", 3'd6, 16'h6D);
        tmr_stop = 1; tick();
        wr(3'd5, 16'h04);
        rd_chk("R8 clear ovf", 3'd6, 16'h69);
        wr(3'd5, 16'h00);
        rd_chk("R8 zero write", 3'd6, 16'h69);
        rd_chk("R8 clr reads 0", 3'd5, 16'h00);

        // R9 / R11 wake handling
        wr(3'd4, 16'h2);
        wr(3'd5, 16'h10);
        rd_chk("R9 enabled kept", 3'd6, 16'h29);
        chk("R11 wake on", 16'(wake), 1);
        wr(3'd4, 16'h0);
        chk("R11 wake off", 16'(wake), 0);
        wr(3'd5, 16'h10);
        rd_chk("R9 cleared", 3'd6, 16'h09);

        // R11 irq
        wr(3'd3, 16'h8);
        chk("R11 irq on", 16'(irq), 1);
        wr(3'd3, 16'h4);
        chk("R11 irq masked", 16'(irq), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule